// File: doc/BRIEF.md
# DPLL Phase Lock Qualifier

This block decides whether a digital PLL is phase locked. On every phase-detector strobe it takes a signed phase error, in fixed fractions of a unit interval, and compares the size of that error with a programmable acceptance window. A free-running 1 ms tick measures how long the error has stayed inside the window. Lock is declared only after an unbroken stay of a programmable number of ticks. A single strobe whose error falls outside the window drops lock on the next clock.

An 8-bit configuration byte sets the behaviour:

- bit 7 turns the window check on.
- bit 6 lets a missing reference count as loss.
- bit 5 is a spare test bit.
- bits 4:3 are unused.
- bits 2:0 hold the window code.

When the window check is off, loss simply follows an external loss request. The two outputs, phase lost and phase locked, are always complements of each other.

Top module: `phase_lock_monitor`

## Requirements
- R1: After reset the configuration byte is 8'hA2 (window check on, no-activity loss off, window code 2), `phase_lost_o` is 1 and `phase_locked_o` is 0.
- R2: `phase_lost_o` is always the complement of `phase_locked_o`.
- R3: `phase_err_i` is a two's-complement value of ERR_W bits in which 2048 counts equal 360 degrees. The window half-width is code × STEP counts, with STEP defaulting to 256. An error is inside the window when its magnitude is at most the half-width, so the boundary value itself is inside.
- R4: With bit 7 = 1, `phase_locked_o` rises in the cycle after the clock edge that samples the QUAL_TICKS-th `tick_i` pulse of a run in which no restart event occurred.
- R5: With bit 7 = 1, a strobe whose error is outside the window makes `phase_locked_o` 0 in the next cycle and restarts the tick count from zero.
- R6: With bit 7 = 1 and window code 000, phase loss is reported continuously, whatever the error and the ticks.
- R7: With bit 6 = 1, `ref_active_i` low reports phase loss in the next cycle and restarts the tick count. With bit 6 = 0, `ref_active_i` low has no effect.
- R8: With bit 7 = 0, the window is ignored and `phase_lost_o` equals the registered value of `ext_loss_i`, OR'ed with the no-activity loss of R7. With bit 7 = 1, `ext_loss_i` is ignored.
- R9: A configuration write makes `phase_locked_o` 0 in the next cycle and restarts the tick count. The written byte governs behaviour from the next cycle on.
- R10: The tick count saturates at QUAL_TICKS, so lock is held through any number of further ticks.
- R11: When `strobe_i` is low, `phase_err_i` is not compared with the window, so any error value leaves the lock state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration byte write strobe |
| cfg_wdata_i | input | 8 | Configuration byte to write |
| strobe_i | input | 1 | Phase error valid |
| phase_err_i | input | ERR_W | Signed phase error (2048 counts = 360 degrees) |
| ref_active_i | input | 1 | Reference activity seen (low means no activity) |
| tick_i | input | 1 | 1 ms qualification tick pulse |
| ext_loss_i | input | 1 | External loss request, used when the window check is off |
| phase_lost_o | output | 1 | Phase lost indication |
| phase_locked_o | output | 1 | Phase locked indication |

## Verification
The window comparison is tried with errors placed exactly on the half-width and one count beyond it, for both signs and for window codes 1, 2 and 7, including the most negative error value. These patterns separate an inclusive comparison from an exclusive one and show whether the magnitude is taken correctly. Long inside-window runs show whether lock comes on the exact tick and whether the count saturates or wraps. Out-of-window errors presented with the strobe low, missing activity with its enable off, and external loss requests with the window active each show whether an input that should be ignored leaks into the outputs. Switching the window check off shows whether loss then follows the external request.

// File: rtl/plm_pkg.sv
package plm_pkg;

   typedef struct packed {
      logic       win_en;     // window check enable
      logic       idle_loss;  // missing reference counts as loss
      logic       test_bit;   // spare test control
      logic [1:0] spare;      // unused
      logic [2:0] win_code;   // window half-width code
   } plm_cfg_t;

   localparam logic [7:0] PLM_CFG_RESET = 8'hA2;

endpackage

// File: rtl/plm_window_cmp.sv
module plm_window_cmp #(
   parameter int ERR_W = 12,
   parameter int STEP  = 256
) (
   input  logic signed [ERR_W-1:0] err_i,
   input  logic [2:0]              code_i,
   output logic                    inside_o
);
   localparam int CMP_W = ERR_W + 4;
   localparam int SH    = $clog2(STEP);

   logic [ERR_W:0]   ext_err;
   logic [ERR_W:0]   mag;
   logic [CMP_W-1:0] half;

   assign ext_err = {err_i[ERR_W-1], err_i};
   assign mag     = err_i[ERR_W-1] ? (~ext_err + 1'b1) : ext_err;

   generate
      if ((1 << SH) == STEP) begin : g_shift
         assign half = CMP_W'(code_i) << SH;
      end else begin : g_mult
         assign half = CMP_W'(code_i) * CMP_W'(STEP);
      end
   endgenerate

   assign inside_o = ({3'b000, mag} <= half);

endmodule

// File: rtl/plm_qual_timer.sv
module plm_qual_timer #(
   parameter int QUAL_W     = 16,
   parameter int QUAL_TICKS = 1500
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              clear_i,
   input  logic              tick_i,
   output logic [QUAL_W-1:0] cnt_o,
   output logic              reach_o
);
   localparam logic [QUAL_W-1:0] LIMIT = QUAL_W'(QUAL_TICKS);

   logic [QUAL_W-1:0] cnt_q;
   logic [QUAL_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (clear_i) begin
         cnt_d = '0;
      end else if (tick_i && (cnt_q != LIMIT)) begin
         cnt_d = cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cnt_q <= '0;
      else         cnt_q <= cnt_d;
   end

   assign cnt_o   = cnt_q;
   assign reach_o = (cnt_d == LIMIT);

endmodule

// File: rtl/phase_lock_monitor.sv
module phase_lock_monitor
   import plm_pkg::*;
#(
   parameter int ERR_W      = 12,
   parameter int STEP       = 256,
   parameter int QUAL_W     = 16,
   parameter int QUAL_TICKS = 1500
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    cfg_wr_i,
   input  logic [7:0]              cfg_wdata_i,
   input  logic                    strobe_i,
   input  logic signed [ERR_W-1:0] phase_err_i,
   input  logic                    ref_active_i,
   input  logic                    tick_i,
   input  logic                    ext_loss_i,
   output logic                    phase_lost_o,
   output logic                    phase_locked_o
);
   generate
      if (ERR_W < 4) begin : g_bad_err_w
         $error("ERR_W must be at least 4");
      end
      if (QUAL_TICKS < 1) begin : g_bad_qual
         $error("QUAL_TICKS must be at least 1");
      end
      if (QUAL_TICKS >= (1 << QUAL_W)) begin : g_bad_qual_w
         $error("QUAL_TICKS does not fit in QUAL_W bits");
      end
      if ((STEP * 7) >= (1 << (ERR_W + 3))) begin : g_bad_step
         $error("STEP too large for the comparison width");
      end
   endgenerate

   logic [7:0]        cfg_q;
   plm_cfg_t          cfg_s;
   logic              in_win;
   logic              idle_evt;
   logic              restart;
   logic              reach;
   logic              locked_d;
   logic              locked_q;
   logic [QUAL_W-1:0] qual_cnt;

   assign cfg_s = plm_cfg_t'(cfg_q);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cfg_q <= PLM_CFG_RESET;
      else if (cfg_wr_i) cfg_q <= cfg_wdata_i;
   end

   plm_window_cmp #(
      .ERR_W (ERR_W),
      .STEP  (STEP)
   ) win_i (
      .err_i    (phase_err_i),
      .code_i   (cfg_s.win_code),
      .inside_o (in_win)
   );

   assign idle_evt = cfg_s.idle_loss && !ref_active_i;
   assign restart  = cfg_wr_i || !cfg_s.win_en || (cfg_s.win_code == 3'd0) ||
                     (strobe_i && !in_win) || idle_evt;

   plm_qual_timer #(
      .QUAL_W     (QUAL_W),
      .QUAL_TICKS (QUAL_TICKS)
   ) tmr_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (restart),
      .tick_i  (tick_i),
      .cnt_o   (qual_cnt),
      .reach_o (reach)
   );

   always_comb begin
      if (cfg_wr_i)          locked_d = 1'b0;
      else if (cfg_s.win_en) locked_d = reach;
      else                   locked_d = !ext_loss_i && !idle_evt;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) locked_q <= 1'b0;
      else         locked_q <= locked_d;
   end

   assign phase_locked_o = locked_q;
   assign phase_lost_o   = !locked_q;

endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
   parameter int QUAL_W     = 16,
   parameter int QUAL_TICKS = 1500
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              cfg_wr_i,
   input logic              strobe_i,
   input logic              ref_active_i,
   input logic              ext_loss_i,
   input logic              phase_lost_o,
   input logic              phase_locked_o,
   input logic [7:0]        cfg_q,
   input logic              in_win,
   input logic [QUAL_W-1:0] qual_cnt
);
   // R2
   complement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_lost_o != phase_locked_o);

   // R9
   cfg_write_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_wr_i |=> !phase_locked_o);

   // R5
   excursion_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[7] && strobe_i && !in_win) |=> phase_lost_o);

   // R6
   zero_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[7] && (cfg_q[2:0] == 3'd0)) |=> phase_lost_o);

   // R7
   idle_loss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q[6] && !ref_active_i) |=> phase_lost_o);

   // R8
   ext_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!cfg_q[7] && !cfg_wr_i) |=>
         (phase_lost_o == $past(ext_loss_i || (cfg_q[6] && !ref_active_i))));

   // R10
   count_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      qual_cnt <= QUAL_W'(QUAL_TICKS));

endmodule

bind phase_lock_monitor plm_checker #(
   .QUAL_W     (QUAL_W),
   .QUAL_TICKS (QUAL_TICKS)
) chk_i (
   .clk_i          (clk_i),
   .rst_ni         (rst_ni),
   .cfg_wr_i       (cfg_wr_i),
   .strobe_i       (strobe_i),
   .ref_active_i   (ref_active_i),
   .ext_loss_i     (ext_loss_i),
   .phase_lost_o   (phase_lost_o),
   .phase_locked_o (phase_locked_o),
   .cfg_q          (cfg_q),
   .in_win         (in_win),
   .qual_cnt       (qual_cnt)
);

// File: tb/phase_lock_monitor_tb_top.sv
module phase_lock_monitor_tb_top;
   localparam int ERR_W = 12;
   localparam int QW    = 4;
   localparam int QT    = 6;

   typedef struct {
      bit    exp;
      string tag;
   } item_t;

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    cfg_wr = 1'b0;
   logic [7:0]              cfg_wdata = 8'h00;
   logic                    strobe = 1'b0;
   logic signed [ERR_W-1:0] perr = '0;
   logic                    act = 1'b1;
   logic                    tick = 1'b0;
   logic                    ext = 1'b0;
   logic                    lost;
   logic                    locked;

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   item_t sb_q[$];

   bit [7:0] m_cfg = 8'hA2;
   int       m_cnt = 0;

   always #4 clk = ~clk;

   phase_lock_monitor #(
      .ERR_W      (ERR_W),
      .STEP       (256),
      .QUAL_W     (QW),
      .QUAL_TICKS (QT)
   ) dut_i (
      .clk_i          (clk),
      .rst_ni         (rst_n),
      .cfg_wr_i       (cfg_wr),
      .cfg_wdata_i    (cfg_wdata),
      .strobe_i       (strobe),
      .phase_err_i    (perr),
      .ref_active_i   (act),
      .tick_i         (tick),
      .ext_loss_i     (ext),
      .phase_lost_o   (lost),
      .phase_locked_o (locked)
   );

   // driver: apply one cycle of stimulus and push the expected lock state
   task automatic step(input bit stb, input int err, input bit a, input bit tk,
                       input bit ex, input bit wr, input bit [7:0] wd, input string tag);
      bit    fine, idle, clr, e;
      int    mag, half;
      item_t it;
      @(negedge clk);
      strobe = stb; perr = ERR_W'(err); act = a; tick = tk; ext = ex;
      cfg_wr = wr; cfg_wdata = wd;
      fine = m_cfg[7];
      half = int'(m_cfg[2:0]) * 256;
      mag  = (err < 0) ? -err : err;
      idle = m_cfg[6] && !a;
      clr  = wr || !fine || (m_cfg[2:0] == 3'd0) || (stb && (mag > half)) || idle;
      if (clr)                  m_cnt = 0;
      else if (tk && m_cnt < QT) m_cnt++;
      if (wr)        e = 1'b0;
      else if (fine) e = !clr && (m_cnt == QT);
      else           e = !ex && !idle;
      if (wr) m_cfg = wd;
      it.exp = e; it.tag = tag;
      sb_q.push_back(it);
   endtask

   task automatic run(input int n, input int err, input string tag);
      for (int i = 0; i < n; i++) step(1'b1, err, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, tag);
   endtask

   task automatic wcfg(input bit [7:0] v, input string tag);
      step(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b1, v, tag);
   endtask

   // monitor: compare results one delta after each clock edge
   always begin
      item_t it;
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
         it = sb_q.pop_front();
         checks++;
         if (locked !== it.exp) begin
            errors++;
            $display("FAIL %s: phase_locked_o=%b expected %b", it.tag, locked, it.exp);
         end
         checks++;
         if (lost !== ~locked) begin
            errors++;
            $display("FAIL R2: phase_lost_o=%b expected %b", lost, ~locked);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not end, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (lost !== 1'b1 || locked !== 1'b0) begin
         errors++;
         $display("FAIL R1: lost=%b locked=%b expected 1/0", lost, locked);
      end
      // R1/R4: default window code 2 -> half-width 512, lock after QT ticks
      run(QT, 500, "R4");
      run(3, 300, "R4");
      // R3: boundary inside, one beyond outside
      run(2, -512, "R3");
      run(1, 512, "R3");
      run(1, 513, "R5");
      run(2, 0, "R5");
      run(QT, -513, "R5");
      run(QT, 0, "R4");
      // R11: out-of-window error with strobe low is ignored
      for (int i = 0; i < 3; i++) step(1'b0, 2000, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, "R11");
      // R10: saturation across many ticks
      run(40, 100, "R10");
      // R7: no-activity with enable off has no effect
      for (int i = 0; i < 3; i++) step(1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");
      // R8: external loss ignored while window on
      for (int i = 0; i < 3; i++) step(1'b1, 0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, "R8");
      // R9: write drops lock and restarts the count
      wcfg(8'hE2, "R9");
      run(QT + 1, 0, "R9");
      // R7: no-activity with enable on
      step(1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, "R7");
      run(QT + 1, 0, "R7");
      // R6: code 000 reports loss continuously
      wcfg(8'hA0, "R6");
      run(10, 0, "R6");
      // R3: code 1 -> half-width 256
      wcfg(8'hA1, "R9");
      run(QT, 256, "R3");
      run(1, -256, "R3");
      run(1, 257, "R3");
      // R3: code 7 -> half-width 1792, most negative error is outside
      wcfg(8'hA7, "R9");
      run(QT, -1792, "R3");
      run(1, -2048, "R3");
      run(2, 1792, "R3");
      // R8: window off, loss follows the external request
      wcfg(8'h22, "R9");
      for (int i = 0; i < 3; i++) step(1'b1, 2000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
      for (int i = 0; i < 2; i++) step(1'b1, 0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, "R8");
      step(1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R8");
      // R7 with window off
      wcfg(8'h62, "R9");
      step(1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
      step(1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
      step(1'b1, 0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
      step(1'b0, 0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R7");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule